// File: doc/BRIEF.md
# Reloading Countdown Timer with Interrupt Flag

This block is a down-counting timer with a register interface of nibble-wide locations. Software writes a reload value, picks one of four tick sources, enables the timer, and then reads the live count or waits for the interrupt. Each accepted tick lowers the count by one. The tick that would bring the count to zero reloads the preset and sets a sticky expiry flag in the same cycle. The timer then runs again without software help.

The four tick sources arrive as single-cycle enable inputs: a fast tick, a slow tick, a once-per-second update and a once-per-minute update. Dividing these from an oscillator is outside the block. Software can clear the flag but never set it. The interrupt output works in one of two modes. In level mode it follows the flag gated by the interrupt enable. In pulse mode every expiry drives a fixed-length pulse, whatever the flag holds.

Top module: `nib_timer`

## Requirements
- R1: After reset, every readable location returns 0 and `irq_o` is low.
- R2: The location map is as follows. Address 0 holds preset bits 3:0 and address 1 holds preset bits 7:4, both read/write. Address 2 returns count bits 3:0 and address 3 returns count bits 7:4; writes to these two are ignored. Address 4 is settings: bit 3 enable, bit 2 mode (0 level, 1 pulse), bits 1:0 source. Address 5 is control: bit 1 flag, bit 0 interrupt enable. Addresses 6 and 7 read 0.
- R3: A settings write that changes enable from 0 to 1 loads the preset into the count at that write's clock edge.
- R4: While enabled, each clock edge with `tick_i[source]` high lowers the count by one. Source code n selects `tick_i[n]`: 0 fast, 1 slow, 2 per-second, 3 per-minute. Ticks on the other bits are ignored.
- R5: An accepted tick that finds the count at 1 reloads the preset and sets the flag at the same edge, so a preset P in 1..255 gives one expiry every P ticks.
- R6: A preset of 0 gives one expiry every 256 ticks, and the count passes through 255 down to 1.
- R7: While enable is 0, the count holds its value and all ticks are ignored.
- R8: Writing control with bit 1 = 0 clears the flag. Writing bit 1 = 1 leaves it unchanged and never sets it. An expiry at the same edge as a clearing write leaves the flag set.
- R9: In level mode `irq_o` is high exactly while the flag is 1 and the interrupt enable is 1.
- R10: In pulse mode with the interrupt enable at 1, each expiry drives `irq_o` high for PULSE_CYCLES clock cycles, starting right after the expiry edge. The flag does not affect this.
- R11: A preset write while the timer runs leaves the current count untouched and takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the addressed location |
| addr_i | input | 3 | Location address for both read and write |
| wdata_i | input | 4 | Write data nibble |
| rdata_o | output | 4 | Read data of the addressed location (combinational) |
| tick_i | input | 4 | One tick-enable per source, high for one cycle per tick |
| irq_o | output | 1 | Interrupt output, level or pulse |

## Verification
Reads are combinational from the registered state, so a value shows at `rdata_o` in the cycle its address is applied. A write, an accepted tick, a reload or a flag change shows one clock edge later. In pulse mode the interrupt is high for the PULSE_CYCLES samples that follow the expiry edge. The bench drives every input on the falling edge and samples 0.5 ns after a falling edge. Each expected count, flag and interrupt value is therefore taken after exactly the rising edge that should produce it. Expected counts come from arithmetic on the tick index modulo 256, swept over all four sources and a set of presets that includes 0, 1 and 255.

// File: rtl/nt_pkg.sv
package nt_pkg;

    // bit positions inside the settings nibble
    localparam int SET_EN_BIT   = 3;
    localparam int SET_MODE_BIT = 2;

    // bit positions inside the control nibble
    localparam int CTL_FLAG_BIT = 1;
    localparam int CTL_IE_BIT   = 0;

    typedef enum logic {
        IRQ_LEVEL = 1'b0,
        IRQ_PULSE = 1'b1
    } irq_mode_e;

    typedef enum logic [1:0] {
        SRC_FAST = 2'd0,
        SRC_SLOW = 2'd1,
        SRC_SEC  = 2'd2,
        SRC_MIN  = 2'd3
    } src_sel_e;

endpackage

// File: rtl/nt_regs.sv
module nt_regs
    import nt_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int NIB_W  = 4,
    parameter int SRC_W  = 2,
    parameter int ADDR_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NIB_W-1:0]  wdata_i,
    output logic [CNT_W-1:0]  preset_o,
    output logic              en_o,
    output irq_mode_e         mode_o,
    output logic [SRC_W-1:0]  src_o,
    output logic              ie_o,
    output logic              load_o,
    output logic              flag_clr_o
);
    localparam int NUM_NIB = CNT_W / NIB_W;
    localparam int A_SET   = 2 * NUM_NIB;
    localparam int A_CTL   = 2 * NUM_NIB + 1;

    typedef struct packed {
        logic [CNT_W-1:0] preset;
        logic             en;
        irq_mode_e        mode;
        logic [SRC_W-1:0] src;
        logic             ie;
    } regs_t;

    regs_t reg_d, reg_q;
    logic  load_d, clr_d;

    always_comb begin
        reg_d  = reg_q;
        load_d = 1'b0;
        clr_d  = 1'b0;
        if (wr_en_i) begin
            for (int i = 0; i < NUM_NIB; i++) begin
                if (addr_i == ADDR_W'(i)) begin
                    reg_d.preset[i*NIB_W +: NIB_W] = wdata_i;
                end
            end
            if (addr_i == ADDR_W'(A_SET)) begin
                reg_d.en   = wdata_i[SET_EN_BIT];
                reg_d.mode = irq_mode_e'(wdata_i[SET_MODE_BIT]);
                reg_d.src  = wdata_i[SRC_W-1:0];
                load_d     = wdata_i[SET_EN_BIT] & ~reg_q.en;
            end
            if (addr_i == ADDR_W'(A_CTL)) begin
                reg_d.ie = wdata_i[CTL_IE_BIT];
                clr_d    = ~wdata_i[CTL_FLAG_BIT];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign preset_o   = reg_q.preset;
    assign en_o       = reg_q.en;
    assign mode_o     = reg_q.mode;
    assign src_o      = reg_q.src;
    assign ie_o       = reg_q.ie;
    assign load_o     = load_d;
    assign flag_clr_o = clr_d;

endmodule

// File: rtl/nt_counter.sv
module nt_counter #(
    parameter int CNT_W   = 8,
    parameter int NUM_SRC = 4,
    parameter int SRC_W   = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] tick_i,
    input  logic [SRC_W-1:0]   src_i,
    input  logic               en_i,
    input  logic               load_i,
    input  logic [CNT_W-1:0]   preset_i,
    output logic [CNT_W-1:0]   count_o,
    output logic               expire_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic tick_sel;
    logic step;
    logic expire_d;

    always_comb begin
        tick_sel = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (src_i == SRC_W'(i)) begin
                tick_sel = tick_i[i];
            end
        end
        step     = en_i & tick_sel;
        expire_d = step & (cnt_q.count == CNT_ONE);

        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d.count = preset_i;
        end else if (expire_d) begin
            cnt_d.count = preset_i;
        end else if (step) begin
            cnt_d.count = cnt_q.count - CNT_ONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o  = cnt_q.count;
    assign expire_o = expire_d;

endmodule

// File: rtl/nt_irq.sv
module nt_irq
    import nt_pkg::*;
#(
    parameter int PULSE_CYCLES = 4
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      expire_i,
    input  logic      flag_clr_i,
    input  logic      ie_i,
    input  irq_mode_e mode_i,
    output logic      flag_o,
    output logic      irq_o
);
    localparam int PW = $clog2(PULSE_CYCLES + 1);
    localparam logic [PW-1:0] P_LEN = PW'(PULSE_CYCLES);

    typedef struct packed {
        logic          flag;
        logic [PW-1:0] pcnt;
    } irq_t;

    irq_t irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        // expiry wins over a clearing write in the same cycle
        if (expire_i) begin
            irq_d.flag = 1'b1;
        end else if (flag_clr_i) begin
            irq_d.flag = 1'b0;
        end
        if (expire_i) begin
            irq_d.pcnt = P_LEN;
        end else if (irq_q.pcnt != '0) begin
            irq_d.pcnt = irq_q.pcnt - PW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            irq_q <= '0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign flag_o = irq_q.flag;
    assign irq_o  = ie_i & ((mode_i == IRQ_PULSE) ? (irq_q.pcnt != '0) : irq_q.flag);

endmodule

// File: rtl/nib_timer.sv
module nib_timer
    import nt_pkg::*;
#(
    parameter  int CNT_W        = 8,
    parameter  int NIB_W        = 4,
    parameter  int NUM_SRC      = 4,
    parameter  int PULSE_CYCLES = 4,
    localparam int NUM_NIB      = CNT_W / NIB_W,
    localparam int ADDR_W       = $clog2(2 * NUM_NIB + 2)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [NIB_W-1:0]   wdata_i,
    output logic [NIB_W-1:0]   rdata_o,
    input  logic [NUM_SRC-1:0] tick_i,
    output logic               irq_o
);
    localparam int SRC_W = $clog2(NUM_SRC);
    localparam int A_SET = 2 * NUM_NIB;
    localparam int A_CTL = 2 * NUM_NIB + 1;

    logic [CNT_W-1:0] preset;
    logic [CNT_W-1:0] count;
    logic             en;
    irq_mode_e        mode;
    logic [SRC_W-1:0] src;
    logic             ie;
    logic             load;
    logic             flag_clr;
    logic             expire;
    logic             flag;

    nt_regs #(
        .CNT_W (CNT_W),
        .NIB_W (NIB_W),
        .SRC_W (SRC_W),
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .preset_o  (preset),
        .en_o      (en),
        .mode_o    (mode),
        .src_o     (src),
        .ie_o      (ie),
        .load_o    (load),
        .flag_clr_o(flag_clr)
    );

    nt_counter #(
        .CNT_W  (CNT_W),
        .NUM_SRC(NUM_SRC),
        .SRC_W  (SRC_W)
    ) u_counter (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick_i),
        .src_i   (src),
        .en_i    (en),
        .load_i  (load),
        .preset_i(preset),
        .count_o (count),
        .expire_o(expire)
    );

    nt_irq #(
        .PULSE_CYCLES(PULSE_CYCLES)
    ) u_irq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .expire_i  (expire),
        .flag_clr_i(flag_clr),
        .ie_i      (ie),
        .mode_i    (mode),
        .flag_o    (flag),
        .irq_o     (irq_o)
    );

    // read multiplexer
    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM_NIB; i++) begin
            if (addr_i == ADDR_W'(i)) begin
                rdata_o = preset[i*NIB_W +: NIB_W];
            end
            if (addr_i == ADDR_W'(NUM_NIB + i)) begin
                rdata_o = count[i*NIB_W +: NIB_W];
            end
        end
        if (addr_i == ADDR_W'(A_SET)) begin
            rdata_o[SET_EN_BIT]   = en;
            rdata_o[SET_MODE_BIT] = mode;
            rdata_o[SRC_W-1:0]    = src;
        end
        if (addr_i == ADDR_W'(A_CTL)) begin
            rdata_o[CTL_FLAG_BIT] = flag;
            rdata_o[CTL_IE_BIT]   = ie;
        end
    end

endmodule

// File: rtl/nt_checker.sv
module nt_checker
    import nt_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int NUM_SRC = 4,
    parameter int SRC_W   = 2
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_SRC-1:0] tick_i,
    input logic [SRC_W-1:0]   src,
    input logic               en,
    input logic               load,
    input logic               expire,
    input logic [CNT_W-1:0]   preset,
    input logic [CNT_W-1:0]   count,
    input logic               flag,
    input logic               ie,
    input irq_mode_e          mode,
    input logic               irq_o
);
    logic sel;
    assign sel = tick_i[src];

    AST_LOAD_ON_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load |=> count == $past(preset)); // R3

    AST_DECREMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en && sel && !expire && !load) |=> count == CNT_W'($past(count) - 1'b1)); // R4

    AST_RELOAD_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire |=> (flag && count == $past(preset))); // R5

    AST_HOLD_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en && !load) |=> $stable(count)); // R7

    AST_FLAG_NO_SW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!flag && !expire) |=> !flag); // R8

    AST_PULSE_AFTER_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (expire && ie && mode == IRQ_PULSE) |=> (irq_o || !ie || mode != IRQ_PULSE)); // R10

endmodule

bind nib_timer nt_checker #(
    .CNT_W  (CNT_W),
    .NUM_SRC(NUM_SRC),
    .SRC_W  (SRC_W)
) u_chk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .src   (src),
    .en    (en),
    .load  (load),
    .expire(expire),
    .preset(preset),
    .count (count),
    .flag  (flag),
    .ie    (ie),
    .mode  (mode),
    .irq_o (irq_o)
);

// File: tb/nib_timer_tb_top.sv
`timescale 1ns/1ps
module nib_timer_tb_top;
    localparam int PULSE = 4;
    localparam logic [2:0] A_PLO = 3'd0, A_PHI = 3'd1, A_CLO = 3'd2, A_CHI = 3'd3;
    localparam logic [2:0] A_SET = 3'd4, A_CTL = 3'd5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [3:0] wdata = '0;
    logic [3:0] rdata;
    logic [3:0] tick = '0;
    logic       irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nib_timer dut_i (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .wr_en_i(wr_en),
        .addr_i (addr),
        .wdata_i(wdata),
        .rdata_o(rdata),
        .tick_i (tick),
        .irq_o  (irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [3:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        addr = a;
        #0.5;
        v = int'(rdata);
    endtask

    task automatic rd_count(output int v);
        int lo, hi;
        rd(A_CLO, lo);
        rd(A_CHI, hi);
        v = hi * 16 + lo;
    endtask

    task automatic rd_flag(output int v);
        int c;
        rd(A_CTL, c);
        v = (c >> 1) & 1;
    endtask

    task automatic do_tick(input logic [3:0] m);
        @(negedge clk);
        tick = m;
        @(negedge clk);
        tick = '0;
    endtask

    task automatic set_preset(input int p);
        wr(A_PLO, 4'(p & 15));
        wr(A_PHI, 4'((p >> 4) & 15));
    endtask

    task automatic setup(input int s, input int p, input bit pm);
        wr(A_SET, {1'b0, pm, 2'(s)});
        wr(A_CTL, 4'h0);
        set_preset(p);
        wr(A_SET, {1'b1, pm, 2'(s)});
    endtask

    task automatic chk_irq(input string req, input int exp);
        #0.5;
        check(req, int'(irq), exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        int v, f;
        int presets[8] = '{1, 2, 3, 7, 16, 100, 255, 0};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every location and irq
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            check("R1 reset read", v, 0);
        end
        chk_irq("R1 reset irq", 0);

        // R2: map, read-only count, unused addresses
        set_preset(8'hA5);
        rd(A_PLO, v); check("R2 preset low nibble", v, 5);
        rd(A_PHI, v); check("R2 preset high nibble", v, 10);
        wr(A_CLO, 4'hF); wr(A_CHI, 4'h7);
        rd_count(v); check("R2 count write ignored", v, 0);
        wr(A_SET, 4'b0111);
        rd(A_SET, v); check("R2 settings readback", v, 7);
        wr(A_CTL, 4'b0011);
        rd(A_CTL, v); check("R2 control readback", v, 1);
        rd(3'd6, v); check("R2 unused addr 6", v, 0);
        rd(3'd7, v); check("R2 unused addr 7", v, 0);
        wr(A_CTL, 4'h0);

        // R3 R4 R5 R6: sweep sources and presets
        for (int s = 0; s < 4; s++) begin
            foreach (presets[j]) begin
                int p, n;
                p = presets[j];
                n = (p == 0) ? 256 : p;
                setup(s, p, 1'b0);
                rd_count(v); check("R3 load on enable", v, p);
                for (int k = 1; k <= n; k++) begin
                    int exp_c;
                    do_tick(4'(~(1 << s)) & 4'hF);
                    rd_count(v);
                    check("R4 other source ignored", v, (k == 1) ? p : ((p - k + 1) & 255));
                    do_tick(4'(1 << s));
                    rd_count(v);
                    exp_c = (k == n) ? p : ((p - k) & 255);
                    if (p == 0) check("R6 count for preset 0", v, exp_c);
                    else if (k == n) check("R5 reload", v, exp_c);
                    else check("R4 decrement", v, exp_c);
                    rd_flag(f);
                    check((p == 0) ? "R6 flag at 256 ticks" : "R5 flag at expiry", f, (k == n) ? 1 : 0);
                end
            end
        end

        // R7: hold while disabled, then re-enable reloads (R3)
        setup(1, 10, 1'b0);
        for (int k = 0; k < 3; k++) do_tick(4'b0010);
        rd_count(v); check("R4 three ticks", v, 7);
        wr(A_SET, 4'b0001);
        for (int k = 0; k < 5; k++) do_tick(4'b1111);
        rd_count(v); check("R7 hold while disabled", v, 7);
        wr(A_SET, 4'b1001);
        rd_count(v); check("R3 reload on re-enable", v, 10);

        // R8: flag write semantics
        setup(0, 1, 1'b0);
        do_tick(4'b0001);
        rd_flag(f); check("R8 flag set by expiry", f, 1);
        wr(A_CTL, 4'b0010);
        rd_flag(f); check("R8 writing 1 keeps flag", f, 1);
        wr(A_CTL, 4'b0000);
        rd_flag(f); check("R8 writing 0 clears flag", f, 0);
        wr(A_CTL, 4'b0010);
        rd_flag(f); check("R8 writing 1 does not set", f, 0);
        @(negedge clk);
        addr = A_CTL; wdata = 4'b0000; wr_en = 1'b1; tick = 4'b0001;
        @(negedge clk);
        wr_en = 1'b0; tick = '0;
        rd_flag(f); check("R8 expiry beats clear", f, 1);

        // R9: level mode
        setup(0, 1, 1'b0);
        wr(A_CTL, 4'b0001);
        chk_irq("R9 no flag no irq", 0);
        do_tick(4'b0001);
        chk_irq("R9 flag and enable", 1);
        wr(A_CTL, 4'b0010);
        chk_irq("R9 enable off", 0);
        wr(A_CTL, 4'b0011);
        chk_irq("R9 enable back on", 1);
        wr(A_CTL, 4'b0001);
        chk_irq("R9 flag cleared", 0);

        // R10: pulse mode
        setup(0, 1, 1'b1);
        wr(A_CTL, 4'b0001);
        chk_irq("R10 idle", 0);
        @(negedge clk);
        tick = 4'b0001;
        @(negedge clk);
        tick = '0;
        for (int i = 0; i < PULSE + 2; i++) begin
            chk_irq("R10 pulse window", (i < PULSE) ? 1 : 0);
            @(negedge clk);
        end
        rd_flag(f); check("R10 flag still set", f, 1);
        chk_irq("R10 no level from flag", 0);

        // R11: preset change while running
        setup(2, 5, 1'b0);
        for (int k = 0; k < 2; k++) do_tick(4'b0100);
        set_preset(9);
        rd_count(v); check("R11 count untouched", v, 3);
        for (int k = 0; k < 3; k++) do_tick(4'b0100);
        rd_count(v); check("R11 new preset at reload", v, 9);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule